// File: doc/BRIEF.md
# Processor Clock Throttle Gate

The block produces a clock-enable for a processor clock so that the processor runs for a chosen fraction of the time. Time is measured in windows of eight prescale ticks, where a tick is a one-cycle strobe from an external prescaler. While throttling is active with a duty code N from 1 to 7, the enable is high for the first N ticks of each window and low for the rest. The result is a run time of N/8, in steps of one eighth. With throttling off, or with the reserved code 000, the enable stays high, so the clock is never fully stopped.

The enable bit and the duty code are only sampled on the tick that closes a window. A setting written in the middle of a window therefore cannot cut a window short or leave a runt enable pulse. A separate edge detector watches the enable bit. When the SMI-on-throttle input is set, it raises a one-cycle request on each clear-to-set transition of the bit, for a downstream SMI controller.

A small state machine holds the gate. FREE means no throttling and the enable is high. RUN is the high part of a throttled window. HALT is the low part of a throttled window. The machine moves only on a tick, and every move uses the window position and configuration that apply after that tick:
- FREE→RUN: throttling starts at a window boundary.
- RUN→HALT: the position reaches the duty code.
- HALT→RUN: a new window starts.
- Any state→FREE: a boundary loads "off" or code 000.

Top module: `throttle_gate`

## Requirements
- R1: During and directly after reset, `clk_en_o` is 1 and `smi_req_o` is 0. The latched enable, the latched duty code and the window position all start at 0.
- R2: While the latched enable is 0, `clk_en_o` stays 1 whatever the duty code is.
- R3: With the latched enable at 1 and a duty code N from 1 to 7, the window position counts ticks modulo 8. The position is 0 after a window boundary. `clk_en_o` is 1 while the position is below N and 0 otherwise, giving a high time of N out of 8 ticks.
- R4: Duty code 000 is reserved. With the latched enable at 1 it behaves as no throttling, and `clk_en_o` stays 1.
- R5: `thr_en_i` and `duty_i` are latched only on the tick that moves the position from 7 to 0. A change at any other time has no effect on `clk_en_o` until that boundary.
- R6: `clk_en_o` changes only on a clock edge where `tick_i` is 1.
- R7: Suppose `smi_on_thr_i` is 1 on the edge where `thr_en_i` is first sampled as 1 after being 0. Then `smi_req_o` is 1 for exactly the following cycle.
- R8: No pulse is raised in any of three cases: `smi_on_thr_i` is 0, `thr_en_i` stays at 1, or `thr_en_i` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle prescale strobe that advances the window position |
| thr_en_i | input | 1 | Throttle enable bit |
| duty_i | input | 3 | Duty code, run time N/8; 000 reserved |
| smi_on_thr_i | input | 1 | Allows an SMI request when throttling is switched on |
| clk_en_o | output | 1 | Clock enable for the processor clock gate |
| smi_req_o | output | 1 | One-cycle SMI request on the enable bit's rising edge |

## Verification
If the window position is wrong, the low part of the enable pattern moves within the window. This shows up as a wrong `clk_en_o` on the very next tick. If the latched configuration is wrong, whether it was loaded too early or not loaded at a boundary, the high count of a whole window is wrong, and this is seen within one window of eight ticks. The bench sweeps every enable and duty combination and disturbs the inputs in the middle of each window. It compares the enable after every tick, and in the idle cycles between ticks, with a position-and-config model. A fault in the edge detector shows at `smi_req_o` on the cycle after the enable bit changes.

// File: rtl/thr_gate_pkg.sv
package thr_gate_pkg;

    // Gate states: FREE = not throttling, RUN = high part of window,
    // HALT = low part of window.
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } thr_state_t;

endpackage

// File: rtl/thr_window_ctr.sv
module thr_window_ctr #(
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic             wrap_o
);

    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    logic [POS_W-1:0] pos_q;

    // Position after the current edge; wraps naturally at 2**POS_W.
    always_comb begin
        pos_nxt_o = tick_i ? pos_q + 1'b1 : pos_q;
        wrap_o    = tick_i && (pos_q == POS_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_nxt_o;
        end
    end

    assign pos_o = pos_q;

endmodule

// File: rtl/thr_cfg_latch.sv
module thr_cfg_latch #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              act_en_o,
    output logic [CODE_W-1:0] act_code_o,
    output logic              nxt_en_o,
    output logic [CODE_W-1:0] nxt_code_o
);

    logic              en_q;
    logic [CODE_W-1:0] code_q;

    // Settings that apply after this edge: new ones only at a boundary.
    always_comb begin
        nxt_en_o   = load_i ? en_i   : en_q;
        nxt_code_o = load_i ? code_i : code_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else begin
            en_q   <= nxt_en_o;
            code_q <= nxt_code_o;
        end
    end

    assign act_en_o   = en_q;
    assign act_code_o = code_q;

endmodule

// File: rtl/thr_smi_edge.sv
module thr_smi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic arm_i,
    output logic pulse_o
);

    logic en_prev_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            en_prev_q <= en_i;
            pulse_q   <= arm_i && en_i && !en_prev_q;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/throttle_gate.sv
module throttle_gate
    import thr_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       thr_en_i,
    input  logic [2:0] duty_i,
    input  logic       smi_on_thr_i,
    output logic       clk_en_o,
    output logic       smi_req_o
);

    localparam int POS_W  = 3;
    localparam int CODE_W = POS_W;
    localparam logic [CODE_W-1:0] CODE_RSVD = '0;

    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  pos_nxt;
    logic              wrap;
    logic              act_en;
    logic [CODE_W-1:0] act_code;
    logic              nxt_en;
    logic [CODE_W-1:0] nxt_code;
    logic              nxt_throttle;
    logic              nxt_in_high;

    thr_state_t state_q;
    thr_state_t state_d;

    thr_window_ctr #(.POS_W(POS_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .pos_o     (pos),
        .pos_nxt_o (pos_nxt),
        .wrap_o    (wrap)
    );

    thr_cfg_latch #(.CODE_W(CODE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wrap),
        .en_i       (thr_en_i),
        .code_i     (duty_i),
        .act_en_o   (act_en),
        .act_code_o (act_code),
        .nxt_en_o   (nxt_en),
        .nxt_code_o (nxt_code)
    );

    thr_smi_edge u_smi (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (thr_en_i),
        .arm_i   (smi_on_thr_i),
        .pulse_o (smi_req_o)
    );

    // Throttling requires the enable and a non-reserved code.
    always_comb begin
        nxt_throttle = nxt_en && (nxt_code != CODE_RSVD);
        nxt_in_high  = pos_nxt < nxt_code;
    end

    // Next state: moves only on a tick.
    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            unique case (state_q)
                ST_FREE: begin
                    // FREE->RUN when a boundary loads a throttling setting.
                    if (nxt_throttle) state_d = nxt_in_high ? ST_RUN : ST_HALT;
                end
                ST_RUN: begin
                    // RUN->HALT at the duty position; RUN->FREE on unload.
                    if (!nxt_throttle)    state_d = ST_FREE;
                    else if (!nxt_in_high) state_d = ST_HALT;
                end
                ST_HALT: begin
                    // HALT->RUN when a new window starts.
                    if (!nxt_throttle)    state_d = ST_FREE;
                    else if (nxt_in_high) state_d = ST_RUN;
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        clk_en_o = (state_q != ST_HALT);
    end

endmodule

// File: rtl/throttle_gate_chk.sv
module throttle_gate_chk
    import thr_gate_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       thr_en_i,
    input logic       smi_on_thr_i,
    input logic       clk_en_o,
    input logic       smi_req_o,
    input logic [2:0] pos,
    input logic       act_en,
    input logic [2:0] act_code,
    input thr_state_t state_q
);

    assert_no_throttle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> clk_en_o);

    assert_low_after_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (act_en && pos >= act_code));

    assert_high_before_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && act_code != 3'd0 && pos < act_code) |-> clk_en_o);

    assert_rsvd_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == 3'd0) |-> clk_en_o);

    assert_cfg_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && pos == 3'd7) |=> ($stable(act_en) && $stable(act_code)));

    assert_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(clk_en_o));

    assert_smi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req_o |=> !smi_req_o);

    assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req_o |-> ($past(thr_en_i) && $past(smi_on_thr_i)));

endmodule

bind throttle_gate throttle_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .thr_en_i     (thr_en_i),
    .smi_on_thr_i (smi_on_thr_i),
    .clk_en_o     (clk_en_o),
    .smi_req_o    (smi_req_o),
    .pos          (pos),
    .act_en       (act_en),
    .act_code     (act_code),
    .state_q      (state_q)
);

// File: tb/throttle_gate_bench.sv
module throttle_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       thr_en_i = 1'b0;
    logic [2:0] duty_i = 3'd0;
    logic       smi_on_thr_i = 1'b0;
    logic       clk_en_o;
    logic       smi_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of window position and latched configuration.
    int m_pos  = 0;
    int m_en   = 0;
    int m_duty = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    throttle_gate u_throttle_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .thr_en_i     (thr_en_i),
        .duty_i       (duty_i),
        .smi_on_thr_i (smi_on_thr_i),
        .clk_en_o     (clk_en_o),
        .smi_req_o    (smi_req_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b (pos=%0d en=%0d duty=%0d)",
                     req, act, exp, m_pos, m_en, m_duty);
        end
    endtask

    function automatic logic model_en();
        if (m_en == 0 || m_duty == 0) return 1'b1;
        return (m_pos < m_duty);
    endfunction

    function automatic string model_req();
        if (m_en == 0)   return "R2";
        if (m_duty == 0) return "R4";
        return "R3";
    endfunction

    // One tick, then two idle cycles in which the enable must hold.
    task automatic do_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        if (m_pos == WIN - 1) begin
            m_en   = int'(thr_en_i);
            m_duty = int'(duty_i);
        end
        m_pos = (m_pos + 1) % WIN;
        check(model_req(), clk_en_o, model_en());
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R6", clk_en_o, model_en());
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", clk_en_o, 1'b1);
        check("R1", smi_req_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", clk_en_o, 1'b1);
        check("R1", smi_req_o, 1'b0);

        // Sweep every enable/duty pair; disturb inputs mid-window (R5).
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 8; d++) begin
                thr_en_i = e[0];
                duty_i   = d[2:0];
                for (int w = 0; w < 2; w++) begin
                    for (int t = 0; t < WIN; t++) begin
                        if (t == 2) begin
                            duty_i   = d[2:0] ^ 3'd5;
                            thr_en_i = ~e[0];
                        end
                        if (t == 5) begin
                            duty_i   = d[2:0];
                            thr_en_i = e[0];
                        end
                        do_tick();
                    end
                end
            end
        end

        // R5: directed mid-window change. Align so the model is at pos 0.
        thr_en_i = 1'b1;
        duty_i   = 3'd1;
        while (m_pos != 0) do_tick();
        for (int t = 0; t < WIN; t++) do_tick();
        duty_i = 3'd7;
        do_tick();
        check("R5", clk_en_o, 1'b0);
        while (m_pos != 0) do_tick();
        check("R5", clk_en_o, 1'b1);
        do_tick();
        check("R5", clk_en_o, 1'b1);

        // R7: rising edge with SMI enabled gives one pulse.
        thr_en_i = 1'b0;
        smi_on_thr_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", smi_req_o, 1'b0);
        thr_en_i = 1'b1;
        @(negedge clk);
        check("R7", smi_req_o, 1'b1);
        @(negedge clk);
        check("R7", smi_req_o, 1'b0);
        // R8: enable held high, then cleared: no pulse.
        repeat (3) begin
            @(negedge clk);
            check("R8", smi_req_o, 1'b0);
        end
        thr_en_i = 1'b0;
        @(negedge clk);
        check("R8", smi_req_o, 1'b0);
        @(negedge clk);
        check("R8", smi_req_o, 1'b0);
        // R8: rising edge while SMI disabled.
        smi_on_thr_i = 1'b0;
        thr_en_i = 1'b1;
        @(negedge clk);
        check("R8", smi_req_o, 1'b0);
        @(negedge clk);
        check("R8", smi_req_o, 1'b0);
        // R7 again after re-arming.
        thr_en_i = 1'b0;
        smi_on_thr_i = 1'b1;
        @(negedge clk);
        thr_en_i = 1'b1;
        @(negedge clk);
        check("R7", smi_req_o, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule